// File: doc/BRIEF.md
# Interrupt Priority Register File

This block stores one priority level per interrupt source and one threshold level per target context for a platform-level interrupt controller. Software reaches it over a plain word-wide register bus made of an address, write data, a write strobe and a read-data return. The stored levels leave the block as flat vectors that feed the controller's arbitration logic.

Every write is legalized before it is stored. The rule depends on the elaborated `MAX_PRIO` value. When `MAX_PRIO+1` is a power of two, the block keeps only the supported low bits of a write, so the write always lands. Otherwise the block drops any write whose value exceeds `MAX_PRIO`.

Each accepted write raises a single-cycle `upd_pulse_o` one cycle later. The arbitration logic uses this pulse to re-evaluate which interrupts to present. Pending bits, enables, claim/complete handling and the arbitration itself live elsewhere.

Top module: `prio_regfile`

## Requirements
- R1: After reset every priority and threshold level reads as 0, both output vectors are all zero and `upd_pulse_o` is low.
- R2: The priority of source n (n counted from 1) is the 32-bit word at `PRIO_BASE + 4*(n-1)`, for n up to `NUM_SOURCES`. It drives slot n-1 of `src_prio_o`, which occupies bits `[(n-1)*PW +: PW]` with PW = ceil(log2(MAX_PRIO+1)).
- R3: The threshold of context c (counted from 0) is the word at offset 0 of its window at `CTX_BASE + c*CTX_STRIDE`. It drives slot c of `ctx_thresh_o`. Every other offset inside a window is unmapped.
- R4: When MAX_PRIO+1 is a power of two, a write to a mapped word stores the written value modulo MAX_PRIO+1 (its low PW bits) and is always accepted.
- R5: When MAX_PRIO+1 is not a power of two, a write of a value no greater than MAX_PRIO is stored. A larger value leaves the register unchanged.
- R6: An accepted write makes `upd_pulse_o` high in exactly the next cycle, for one cycle only.
- R7: A dropped write, a write to an unmapped address, or a cycle without a write produces no update pulse and changes no stored level.
- R8: A read of a mapped word returns its stored level zero-extended to 32 bits. Any unmapped or misaligned address reads as 0.
- R9: A write to one word leaves every other priority and threshold unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 32 | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_prio_o | output | NUM_SOURCES*PW | Packed source priorities, slot k is source k+1 |
| ctx_thresh_o | output | NUM_CONTEXTS*PW | Packed context thresholds |
| upd_pulse_o | output | 1 | One-cycle pulse after an accepted write |

## Verification
Two instances run side by side, one with a level count that is a power of two and one without. The same write patterns therefore separate masking from dropping. The values written are:
- in-range values, which both modes must store unchanged;
- values with bits above the supported width, which the masking instance truncates and the dropping instance refuses;
- the exact boundary value MAX_PRIO, which must be accepted.

Writes to the first and last source, to each context window, to non-zero offsets inside a window, to the word just past the last source and to a misaligned address separate correct decode from off-by-one decode. After every write, the full output vectors are compared with a bench model, which exposes stray writes into neighbouring slots.

// File: rtl/prio_regs_pkg.sv
package prio_regs_pkg;

  // True when the count of levels (max_prio+1) is a power of two.
  function automatic bit levels_pow2(input int unsigned max_prio);
    return ((max_prio + 1) & max_prio) == 0;
  endfunction

  // Whether a written value may be stored at all.
  function automatic bit write_allowed(input logic [31:0] v, input int unsigned max_prio);
    if (levels_pow2(max_prio)) return 1'b1;
    return v <= 32'(max_prio);
  endfunction

  // Value that is kept; in masking mode this equals v modulo (max_prio+1).
  function automatic logic [31:0] legal_value(input logic [31:0] v, input int unsigned max_prio);
    if (levels_pow2(max_prio)) return v & 32'(max_prio);
    return v;
  endfunction

  // Register width for a given top level, never below one bit.
  function automatic int unsigned level_width(input int unsigned max_prio);
    return (max_prio < 1) ? 1 : $clog2(max_prio + 1);
  endfunction

endpackage

// File: rtl/prio_addr_dec.sv
module prio_addr_dec #(
  parameter int unsigned NUM_SOURCES  = 8,
  parameter int unsigned NUM_CONTEXTS = 2,
  parameter logic [31:0] PRIO_BASE    = 32'h0000_0000,
  parameter logic [31:0] CTX_BASE     = 32'h0020_0000,
  parameter logic [31:0] CTX_STRIDE   = 32'h0000_1000,
  localparam int unsigned SIW = (NUM_SOURCES  > 1) ? $clog2(NUM_SOURCES)  : 1,
  localparam int unsigned CIW = (NUM_CONTEXTS > 1) ? $clog2(NUM_CONTEXTS) : 1
) (
  input  logic [31:0]    addr,
  output logic           pri_hit,
  output logic [SIW-1:0] pri_idx,
  output logic           ctx_hit,
  output logic [CIW-1:0] ctx_idx
);
  localparam int unsigned STRIDE_SH = $clog2(CTX_STRIDE);
  localparam logic [32:0] PRI_SPAN  = 33'(NUM_SOURCES) * 33'd4;
  localparam logic [32:0] CTX_SPAN  = 33'(NUM_CONTEXTS) * 33'(CTX_STRIDE);
  localparam logic [31:0] IN_MASK   = CTX_STRIDE - 32'd1;

  logic [31:0] pri_off;
  logic [31:0] ctx_off;
  logic [31:0] ctx_word;

  always_comb begin
    pri_off  = addr - PRIO_BASE;
    ctx_off  = addr - CTX_BASE;
    ctx_word = ctx_off >> STRIDE_SH;
    pri_hit  = (addr >= PRIO_BASE) && ({1'b0, pri_off} < PRI_SPAN) && (pri_off[1:0] == 2'b00);
    ctx_hit  = (addr >= CTX_BASE) && ({1'b0, ctx_off} < CTX_SPAN) && ((ctx_off & IN_MASK) == 32'd0);
    pri_idx  = pri_off[SIW+1:2];
    ctx_idx  = ctx_word[CIW-1:0];
  end
endmodule

// File: rtl/prio_legalizer.sv
module prio_legalizer
  import prio_regs_pkg::*;
#(
  parameter int unsigned MAX_PRIO = 7,
  localparam int unsigned PW = level_width(MAX_PRIO)
) (
  input  logic [31:0]   wdata,
  output logic          accept,
  output logic [PW-1:0] value
);
  logic [31:0] kept;

  generate
    if (levels_pow2(MAX_PRIO)) begin : g_mask
      // Every bit write-any, read-legal: upper bits fall away.
      always_comb begin
        accept = write_allowed(wdata, MAX_PRIO);
        kept   = legal_value(wdata, MAX_PRIO);
        value  = kept[PW-1:0];
      end
    end else begin : g_drop
      // Out-of-range values are refused outright.
      always_comb begin
        accept = write_allowed(wdata, MAX_PRIO);
        kept   = wdata;
        value  = kept[PW-1:0];
      end
    end
  endgenerate
endmodule

// File: rtl/prio_bank.sv
module prio_bank #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3,
  parameter int unsigned PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [PW-1:0] wr_val,
  input  logic [IW-1:0] rd_idx,
  output logic [PW-1:0] rd_val,
  output logic [N*PW-1:0] flat_o
);
  logic [PW-1:0] level_q [N];

  generate
    for (genvar g = 0; g < N; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          level_q[g] <= '0;
        end else if (wr_en && (wr_idx == IW'(g))) begin
          level_q[g] <= wr_val;
        end
      end
      assign flat_o[g*PW +: PW] = level_q[g];
    end
  endgenerate

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < N; k++) begin
      if (rd_idx == IW'(k)) rd_val = level_q[k];
    end
  end
endmodule

// File: rtl/prio_regfile.sv
module prio_regfile
  import prio_regs_pkg::*;
#(
  parameter int unsigned NUM_SOURCES  = 8,
  parameter int unsigned NUM_CONTEXTS = 2,
  parameter int unsigned MAX_PRIO     = 7,
  parameter logic [31:0] PRIO_BASE    = 32'h0000_0000,
  parameter logic [31:0] CTX_BASE     = 32'h0020_0000,
  parameter logic [31:0] CTX_STRIDE   = 32'h0000_1000,
  localparam int unsigned PW  = level_width(MAX_PRIO),
  localparam int unsigned SIW = (NUM_SOURCES  > 1) ? $clog2(NUM_SOURCES)  : 1,
  localparam int unsigned CIW = (NUM_CONTEXTS > 1) ? $clog2(NUM_CONTEXTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [31:0]                bus_addr,
  input  logic [31:0]                bus_wdata,
  input  logic                       bus_we,
  output logic [31:0]                bus_rdata,
  output logic [NUM_SOURCES*PW-1:0]  src_prio_o,
  output logic [NUM_CONTEXTS*PW-1:0] ctx_thresh_o,
  output logic                       upd_pulse_o
);
  // Named internal events, observed by the bound checker.
  logic           pri_hit;
  logic           ctx_hit;
  logic [SIW-1:0] pri_idx;
  logic [CIW-1:0] ctx_idx;
  logic           legal_ok;
  logic [PW-1:0]  legal_val;
  logic           wr_hit;
  logic           wr_accept;
  logic           wr_src;
  logic           wr_ctx;
  logic [PW-1:0]  src_rd;
  logic [PW-1:0]  ctx_rd;
  logic           upd_q;

  prio_addr_dec #(
    .NUM_SOURCES (NUM_SOURCES),
    .NUM_CONTEXTS(NUM_CONTEXTS),
    .PRIO_BASE   (PRIO_BASE),
    .CTX_BASE    (CTX_BASE),
    .CTX_STRIDE  (CTX_STRIDE)
  ) u_dec (
    .addr   (bus_addr),
    .pri_hit(pri_hit),
    .pri_idx(pri_idx),
    .ctx_hit(ctx_hit),
    .ctx_idx(ctx_idx)
  );

  prio_legalizer #(.MAX_PRIO(MAX_PRIO)) u_legal (
    .wdata (bus_wdata),
    .accept(legal_ok),
    .value (legal_val)
  );

  assign wr_hit    = bus_we && (pri_hit || ctx_hit);
  assign wr_accept = wr_hit && legal_ok;
  assign wr_src    = wr_accept && pri_hit;
  assign wr_ctx    = wr_accept && ctx_hit;

  prio_bank #(.N(NUM_SOURCES), .IW(SIW), .PW(PW)) u_src_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_src),
    .wr_idx(pri_idx),
    .wr_val(legal_val),
    .rd_idx(pri_idx),
    .rd_val(src_rd),
    .flat_o(src_prio_o)
  );

  prio_bank #(.N(NUM_CONTEXTS), .IW(CIW), .PW(PW)) u_ctx_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_ctx),
    .wr_idx(ctx_idx),
    .wr_val(legal_val),
    .rd_idx(ctx_idx),
    .rd_val(ctx_rd),
    .flat_o(ctx_thresh_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_q <= 1'b0;
    else        upd_q <= wr_accept;
  end
  assign upd_pulse_o = upd_q;

  always_comb begin
    if (pri_hit)      bus_rdata = 32'(src_rd);
    else if (ctx_hit) bus_rdata = 32'(ctx_rd);
    else              bus_rdata = 32'd0;
  end
endmodule

// File: rtl/prio_regfile_chk.sv
module prio_regfile_chk #(
  parameter int unsigned NUM_SOURCES  = 8,
  parameter int unsigned NUM_CONTEXTS = 2,
  parameter int unsigned MAX_PRIO     = 7,
  parameter int unsigned PW           = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       pri_hit,
  input logic                       ctx_hit,
  input logic                       wr_accept,
  input logic                       upd_pulse_o,
  input logic [31:0]                bus_rdata,
  input logic [NUM_SOURCES*PW-1:0]  src_prio_o,
  input logic [NUM_CONTEXTS*PW-1:0] ctx_thresh_o
);
  // R6
  upd_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> upd_pulse_o);

  // R7
  no_stray_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_accept |=> !upd_pulse_o);

  // R7
  levels_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_accept |=> ($stable(src_prio_o) && $stable(ctx_thresh_o)));

  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pri_hit || ctx_hit) |-> (bus_rdata == 32'd0));

  // R8
  rdata_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata >> PW) == 32'd0);

  generate
    for (genvar k = 0; k < NUM_SOURCES; k++) begin : g_src_chk
      // R5
      src_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(src_prio_o[k*PW +: PW]) <= 32'(MAX_PRIO));
    end
    for (genvar k = 0; k < NUM_CONTEXTS; k++) begin : g_ctx_chk
      // R5
      ctx_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(ctx_thresh_o[k*PW +: PW]) <= 32'(MAX_PRIO));
    end
  endgenerate
endmodule

bind prio_regfile prio_regfile_chk #(
  .NUM_SOURCES (NUM_SOURCES),
  .NUM_CONTEXTS(NUM_CONTEXTS),
  .MAX_PRIO    (MAX_PRIO),
  .PW          (PW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pri_hit     (pri_hit),
  .ctx_hit     (ctx_hit),
  .wr_accept   (wr_accept),
  .upd_pulse_o (upd_pulse_o),
  .bus_rdata   (bus_rdata),
  .src_prio_o  (src_prio_o),
  .ctx_thresh_o(ctx_thresh_o)
);

// File: tb/sim_prio_regfile.sv
module sim_prio_regfile;
  localparam int NS = 8;
  localparam int NC = 2;
  localparam int PW = 3;
  localparam logic [31:0] CBASE = 32'h0020_0000;
  localparam logic [31:0] CSTR  = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic [31:0] wdata = '0;
  logic we0 = 1'b0;
  logic we1 = 1'b0;
  logic [31:0] rd0, rd1;
  logic [NS*PW-1:0] sp0, sp1;
  logic [NC*PW-1:0] th0, th1;
  logic up0, up1;

  int checks = 0;
  int fails = 0;

  int unsigned m_src [2][NS];
  int unsigned m_thr [2][NC];

  always #10 clk = ~clk;

  // Masking instance: 8 levels.
  prio_regfile #(.NUM_SOURCES(NS), .NUM_CONTEXTS(NC), .MAX_PRIO(7),
                 .CTX_BASE(CBASE), .CTX_STRIDE(CSTR)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we0),
    .bus_rdata(rd0), .src_prio_o(sp0), .ctx_thresh_o(th0), .upd_pulse_o(up0));

  // Dropping instance: 6 levels.
  prio_regfile #(.NUM_SOURCES(NS), .NUM_CONTEXTS(NC), .MAX_PRIO(5),
                 .CTX_BASE(CBASE), .CTX_STRIDE(CSTR)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we1),
    .bus_rdata(rd1), .src_prio_o(sp1), .ctx_thresh_o(th1), .upd_pulse_o(up1));

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Compare both packed vectors of one instance with the model.
  task automatic check_outputs(input int d, input string req);
    for (int k = 0; k < NS; k++) begin
      logic [PW-1:0] v;
      v = (d == 0) ? sp0[k*PW +: PW] : sp1[k*PW +: PW];
      check(req, $sformatf("dut%0d src slot %0d", d, k), 32'(v), m_src[d][k]);
    end
    for (int k = 0; k < NC; k++) begin
      logic [PW-1:0] v;
      v = (d == 0) ? th0[k*PW +: PW] : th1[k*PW +: PW];
      check(req, $sformatf("dut%0d ctx slot %0d", d, k), 32'(v), m_thr[d][k]);
    end
  endtask

  task automatic do_read(input int d, input logic [31:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    addr = a;
    #1;
    check(req, $sformatf("dut%0d read 0x%0h", d, a), (d == 0) ? rd0 : rd1, exp);
  endtask

  // Write, update the model from the requirements, then check pulse and outputs.
  task automatic do_write(input int d, input logic [31:0] a, input logic [31:0] v, input string req);
    int unsigned maxp;
    bit pow2, ok, is_src, is_ctx;
    int idx;
    maxp = (d == 0) ? 7 : 5;
    pow2 = ((maxp + 1) & maxp) == 0;
    ok = pow2 || (v <= maxp);
    is_src = (a < NS * 4) && (a[1:0] == 2'b00);
    is_ctx = (a >= CBASE) && (a < CBASE + NC * CSTR) && (((a - CBASE) & (CSTR - 1)) == 0);
    @(negedge clk);
    addr = a;
    wdata = v;
    if (d == 0) we0 = 1'b1; else we1 = 1'b1;
    @(negedge clk);
    we0 = 1'b0;
    we1 = 1'b0;
    if (ok && is_src) begin
      idx = int'(a >> 2);
      m_src[d][idx] = pow2 ? (v % (maxp + 1)) : v;
    end
    if (ok && is_ctx) begin
      idx = int'((a - CBASE) / CSTR);
      m_thr[d][idx] = pow2 ? (v % (maxp + 1)) : v;
    end
    check("R6", $sformatf("dut%0d pulse after 0x%0h<=0x%0h", d, a, v),
          32'((d == 0) ? up0 : up1), 32'(ok && (is_src || is_ctx)));
    check_outputs(d, req);
    @(negedge clk);
    check("R6", $sformatf("dut%0d pulse width", d), 32'((d == 0) ? up0 : up1), 32'd0);
  endtask

  task automatic t_reset;
    check("R1", "dut0 pulse", 32'(up0), 0);
    check("R1", "dut1 pulse", 32'(up1), 0);
    check_outputs(0, "R1");
    check_outputs(1, "R1");
    do_read(0, 32'h0, 0, "R1");
    do_read(1, CBASE + CSTR, 0, "R1");
  endtask

  task automatic t_map;
    do_write(0, 32'h0, 32'd3, "R2");
    do_read(0, 32'h0, 3, "R2");
    do_write(0, 32'h1C, 32'd6, "R2");
    do_read(0, 32'h1C, 6, "R2");
    do_write(0, CBASE + CSTR, 32'd2, "R3");
    do_read(0, CBASE + CSTR, 2, "R3");
    do_write(0, CBASE + 32'h4, 32'd5, "R3");
    do_read(0, CBASE + 32'h4, 0, "R3");
  endtask

  task automatic t_mask;
    do_write(0, 32'h4, 32'h2D, "R4");
    do_read(0, 32'h4, 32'h5, "R8");
    do_write(0, 32'h4, 32'hFFFF_FFF8, "R4");
    do_read(0, 32'h4, 0, "R4");
    do_write(0, CBASE, 32'h13, "R4");
    do_read(0, CBASE, 3, "R4");
    do_write(0, 32'h8, 32'd7, "R4");
  endtask

  task automatic t_drop;
    do_write(1, 32'h8, 32'd4, "R5");
    do_write(1, 32'h8, 32'd6, "R5");
    do_read(1, 32'h8, 4, "R5");
    do_write(1, 32'h8, 32'd5, "R5");
    do_read(1, 32'h8, 5, "R5");
    do_write(1, CBASE + CSTR, 32'd9, "R5");
    do_write(1, CBASE + CSTR, 32'd1, "R5");
    do_read(1, CBASE + CSTR, 1, "R5");
  endtask

  task automatic t_unmapped;
    do_write(0, 32'h20, 32'd1, "R7");
    do_write(0, 32'h6, 32'd1, "R7");
    do_write(1, CBASE + 2 * CSTR, 32'd1, "R7");
    do_read(0, 32'h20, 0, "R8");
    do_read(0, 32'h2, 0, "R8");
    do_read(0, CBASE + 32'h8, 0, "R8");
  endtask

  task automatic t_isolation;
    do_write(0, 32'h10, 32'd1, "R9");
    do_write(1, 32'h0, 32'd2, "R9");
    check_outputs(0, "R9");
    check_outputs(1, "R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int d = 0; d < 2; d++) begin
      for (int k = 0; k < NS; k++) m_src[d][k] = 0;
      for (int k = 0; k < NC; k++) m_thr[d][k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_mask();
    t_drop();
    t_unmapped();
    t_isolation();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule